// File: doc/BRIEF.md
# Internal Bit Clock Generator

This block produces the serial bit clock for an audio interface running in internal bit-clock mode. It runs entirely on the master clock. It times the word clock by counting master-clock cycles from one rising edge of the word clock to the next. It accepts only three master-to-word-clock ratios: 256, 384 and 512. It reports which ratio it found, and it declares lock once the same ratio has been seen twice in a row.

While locked and in internal mode, the block divides the master clock down to a bit clock. The divider depends on both the detected ratio and the data format (I2S or left-justified). This gives 32, 48 or 64 bit-clock periods per sample, each with a 50% duty cycle. The divider phase restarts at every rising edge of the word clock, so the bit clock stays aligned to the frame.

In external mode the bit-clock output is held low, and ratio detection and lock tracking keep running. Capturing the serial data belongs to a neighbouring block.

Top module: `bclk_gen`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `bclk`, `locked` and `ratio_code` are all 0.
- R2: The period is the number of master-clock cycles from one sampled rising edge of `wclk_in` to the next. Periods of 256, 384 and 512 are reported on `ratio_code` as 1, 2 and 3. The code is updated on the clock edge that samples the closing rising edge. While `locked` is 1, `ratio_code` is never 0.
- R3: A measured period other than 256, 384 or 512 sets `ratio_code` to 0 and clears `locked`. So does a word clock with no rising edge for more than 512 cycles; in that case the change happens on the edge where the count passes 512, without waiting for the next rising edge.
- R4: `locked` goes to 1 only on the edge that takes a valid measurement equal to the previous measurement. The first rising edge after reset takes no measurement.
- R5: A valid measurement that differs from the previous one clears `locked` at once, and `ratio_code` takes the new code.
- R6: `bclk` stays 0 in every cycle that follows a cycle in which `locked` was 0.
- R7: While locked, the divider is set from the ratio and the format (`fmt_lj`: 0 = I2S, 1 = left-justified). The divider is 8 for I2S at 256, 8 for I2S at 384, 16 for I2S at 512, 4 for left-justified at 256, 8 for left-justified at 384 and 8 for left-justified at 512. This gives 32, 48, 32, 64, 48 and 64 `bclk` rising edges per frame. Within each divider period, `bclk` is low for the first half and high for the second half.
- R8: On the edge that samples a rising edge of `wclk_in`, the divider phase restarts. `bclk` is then 0, and it first goes high half a divider period later.
- R9: While `ext_mode` is 1, `bclk` is 0 in the next cycle. Measurement, `locked` and `ratio_code` keep behaving as in R2 to R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| wclk_in | input | 1 | Word clock, sampled on `clk` |
| fmt_lj | input | 1 | Data format: 0 = I2S, 1 = left-justified |
| ext_mode | input | 1 | 1 = external bit clock (generator output held low) |
| bclk | output | 1 | Generated bit clock, registered |
| locked | output | 1 | Ratio stable over two consecutive measurements |
| ratio_code | output | 2 | 0 = none, 1 = 256, 2 = 384, 3 = 512 |

## Verification
A wrong period count shows on `ratio_code` on the edge that ends the first faulty frame. A lock flag that is set or cleared on the wrong measurement shows one frame early or one frame late. A wrong divider choice or a phase that is not restarted shows on `bclk` within one divider period, either as the wrong number of rising edges per frame or as an edge that is not aligned with the word clock. The bench keeps a behavioural model of the counts, codes and phase, and compares all three outputs against it on every cycle, so any of these faults is reported in the cycle where it first appears.

// File: rtl/bclk_gen_pkg.sv
package bclk_gen_pkg;

  typedef enum logic [1:0] {
    RC_NONE = 2'd0,
    RC_LOW  = 2'd1,
    RC_MID  = 2'd2,
    RC_HIGH = 2'd3
  } ratio_e;

endpackage

// File: rtl/wclk_period_meter.sv
module wclk_period_meter
  import bclk_gen_pkg::*;
#(
  parameter int unsigned LOW_RATIO  = 256,
  parameter int unsigned MID_RATIO  = 384,
  parameter int unsigned HIGH_RATIO = 512,
  localparam int CW = $clog2(HIGH_RATIO + 1)
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   wclk_i,
  output logic   rise_o,
  output logic   meas_vld_o,
  output ratio_e meas_code_o,
  output logic   overrun_o
);

  logic          wclk_q;
  logic [CW-1:0] cnt;
  logic          seen;
  logic [CW:0]   period;

  assign rise_o     = wclk_i & ~wclk_q;
  assign meas_vld_o = rise_o & seen;
  assign overrun_o  = ~rise_o & (cnt == CW'(HIGH_RATIO));

  always_comb begin
    period      = {1'b0, cnt} + (CW+1)'(1);
    meas_code_o = RC_NONE;
    if (period == (CW+1)'(LOW_RATIO))       meas_code_o = RC_LOW;
    else if (period == (CW+1)'(MID_RATIO))  meas_code_o = RC_MID;
    else if (period == (CW+1)'(HIGH_RATIO)) meas_code_o = RC_HIGH;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wclk_q <= 1'b0;
      cnt    <= '0;
      seen   <= 1'b0;
    end else begin
      wclk_q <= wclk_i;
      if (rise_o) begin
        cnt  <= '0;
        seen <= 1'b1;
      end else if (cnt != CW'(HIGH_RATIO)) begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  // R3: a stalled word clock keeps the count pinned at the limit
  assert_count_pinned_R3: assert property (@(posedge clk) disable iff (rst)
    overrun_o |=> (cnt == CW'(HIGH_RATIO)) || $past(rst))
    else $error("count left the limit without an edge");

endmodule

// File: rtl/ratio_lock_tracker.sv
module ratio_lock_tracker
  import bclk_gen_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   meas_vld_i,
  input  ratio_e meas_code_i,
  input  logic   overrun_i,
  output logic   lock_o,
  output ratio_e code_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_o <= 1'b0;
      code_o <= RC_NONE;
    end else if (meas_vld_i) begin
      if (meas_code_i == RC_NONE) begin
        lock_o <= 1'b0;
        code_o <= RC_NONE;
      end else if (meas_code_i == code_o) begin
        lock_o <= 1'b1;
      end else begin
        lock_o <= 1'b0;
        code_o <= meas_code_i;
      end
    end else if (overrun_i) begin
      lock_o <= 1'b0;
      code_o <= RC_NONE;
    end
  end

  // R4: lock only rises on a measurement edge
  assert_lock_on_measure_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_o) |-> $past(meas_vld_i))
    else $error("lock rose without a measurement");

  // R3: an unsupported period clears lock and code
  assert_bad_period_drops_R3: assert property (@(posedge clk) disable iff (rst)
    (meas_vld_i && meas_code_i == RC_NONE) |=> (!lock_o && code_o == RC_NONE))
    else $error("bad period did not drop lock");

  // R5: a differing valid code unlocks
  assert_mismatch_unlocks_R5: assert property (@(posedge clk) disable iff (rst)
    (meas_vld_i && meas_code_i != RC_NONE && meas_code_i != code_o) |=> !lock_o)
    else $error("mismatch kept lock");

endmodule

// File: rtl/bclk_divider.sv
module bclk_divider
  import bclk_gen_pkg::*;
#(
  parameter int unsigned DIV_I2S_LOW  = 8,
  parameter int unsigned DIV_I2S_MID  = 8,
  parameter int unsigned DIV_I2S_HIGH = 16,
  parameter int unsigned DIV_LJ_LOW   = 4,
  parameter int unsigned DIV_LJ_MID   = 8,
  parameter int unsigned DIV_LJ_HIGH  = 8,
  parameter int unsigned MAX_DIV      = 16,
  localparam int DW = $clog2(MAX_DIV + 1)
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   rise_i,
  input  logic   enable_i,
  input  ratio_e ratio_i,
  input  logic   fmt_lj_i,
  output logic   bclk_o
);

  logic [DW-1:0] div, half, ph, ph_n;

  always_comb begin
    case (ratio_i)
      RC_LOW:  div = fmt_lj_i ? DW'(DIV_LJ_LOW)  : DW'(DIV_I2S_LOW);
      RC_MID:  div = fmt_lj_i ? DW'(DIV_LJ_MID)  : DW'(DIV_I2S_MID);
      RC_HIGH: div = fmt_lj_i ? DW'(DIV_LJ_HIGH) : DW'(DIV_I2S_HIGH);
      default: div = DW'(DIV_I2S_LOW);
    endcase
    half = div >> 1;
    if (rise_i)                    ph_n = '0;
    else if (ph >= div - DW'(1))   ph_n = '0;
    else                           ph_n = ph + DW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= '0;
      bclk_o <= 1'b0;
    end else begin
      ph     <= ph_n;
      bclk_o <= enable_i && (ph_n >= half);
    end
  end

  // R8: a word-clock edge restarts the phase with the bit clock low
  assert_phase_realign_R8: assert property (@(posedge clk) disable iff (rst)
    rise_i |=> (ph == '0 && !bclk_o))
    else $error("phase not restarted on word-clock edge");

endmodule

// File: rtl/bclk_gen.sv
module bclk_gen
  import bclk_gen_pkg::*;
#(
  parameter int unsigned LOW_RATIO    = 256,
  parameter int unsigned MID_RATIO    = 384,
  parameter int unsigned HIGH_RATIO   = 512,
  parameter int unsigned DIV_I2S_LOW  = 8,
  parameter int unsigned DIV_I2S_MID  = 8,
  parameter int unsigned DIV_I2S_HIGH = 16,
  parameter int unsigned DIV_LJ_LOW   = 4,
  parameter int unsigned DIV_LJ_MID   = 8,
  parameter int unsigned DIV_LJ_HIGH  = 8,
  parameter int unsigned MAX_DIV      = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wclk_in,
  input  logic       fmt_lj,
  input  logic       ext_mode,
  output logic       bclk,
  output logic       locked,
  output logic [1:0] ratio_code
);

  logic   rise, meas_vld, overrun;
  ratio_e meas_code, cur_code;

  wclk_period_meter #(
    .LOW_RATIO (LOW_RATIO),
    .MID_RATIO (MID_RATIO),
    .HIGH_RATIO(HIGH_RATIO)
  ) u_meter (
    .clk        (clk),
    .rst        (rst),
    .wclk_i     (wclk_in),
    .rise_o     (rise),
    .meas_vld_o (meas_vld),
    .meas_code_o(meas_code),
    .overrun_o  (overrun)
  );

  ratio_lock_tracker u_track (
    .clk        (clk),
    .rst        (rst),
    .meas_vld_i (meas_vld),
    .meas_code_i(meas_code),
    .overrun_i  (overrun),
    .lock_o     (locked),
    .code_o     (cur_code)
  );

  bclk_divider #(
    .DIV_I2S_LOW (DIV_I2S_LOW),
    .DIV_I2S_MID (DIV_I2S_MID),
    .DIV_I2S_HIGH(DIV_I2S_HIGH),
    .DIV_LJ_LOW  (DIV_LJ_LOW),
    .DIV_LJ_MID  (DIV_LJ_MID),
    .DIV_LJ_HIGH (DIV_LJ_HIGH),
    .MAX_DIV     (MAX_DIV)
  ) u_div (
    .clk     (clk),
    .rst     (rst),
    .rise_i  (rise),
    .enable_i(locked & ~ext_mode),
    .ratio_i (cur_code),
    .fmt_lj_i(fmt_lj),
    .bclk_o  (bclk)
  );

  assign ratio_code = cur_code;

  // R6: no bit clock after an unlocked cycle
  assert_quiet_unlocked_R6: assert property (@(posedge clk) disable iff (rst)
    !locked |=> !bclk)
    else $error("bclk toggled while unlocked");

  // R9: external mode silences the generator
  assert_quiet_external_R9: assert property (@(posedge clk) disable iff (rst)
    ext_mode |=> !bclk)
    else $error("bclk toggled in external mode");

  // R2: a locked block always reports a real ratio
  assert_code_when_locked_R2: assert property (@(posedge clk) disable iff (rst)
    locked |-> (ratio_code != 2'd0))
    else $error("locked with empty ratio code");

endmodule

// File: tb/test_bclk_gen.sv
`timescale 1ns/1ps
module test_bclk_gen;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wclk_in = 1'b0;
  logic       fmt_lj = 1'b0;
  logic       ext_mode = 1'b0;
  logic       bclk, locked;
  logic [1:0] ratio_code;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit pb = 0;

  always #2.5 clk = ~clk;

  bclk_gen i_bclk_gen (
    .clk(clk), .rst(rst), .wclk_in(wclk_in), .fmt_lj(fmt_lj),
    .ext_mode(ext_mode), .bclk(bclk), .locked(locked), .ratio_code(ratio_code)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  function automatic int cls(input int p);
    if (p == 256) return 1;
    if (p == 384) return 2;
    if (p == 512) return 3;
    return 0;
  endfunction

  function automatic int mdiv(input int c, input bit lj);
    case (c)
      1: return lj ? 4 : 8;
      2: return 8;
      3: return lj ? 8 : 16;
      default: return 8;
    endcase
  endfunction

  int m_pw, m_cnt, m_seen, m_cand, m_lock, m_ph, m_bclk;

  always @(posedge clk) begin
    int rise, dv, phn, code;
    if (rst) begin
      m_pw = 0; m_cnt = 0; m_seen = 0; m_cand = 0; m_lock = 0; m_ph = 0; m_bclk = 0;
    end else begin
      rise = (wclk_in && !m_pw) ? 1 : 0;
      dv = mdiv(m_cand, fmt_lj);
      if (rise != 0) phn = 0;
      else if (m_ph >= dv - 1) phn = 0;
      else phn = m_ph + 1;
      m_bclk = (m_lock != 0 && !ext_mode && phn >= dv / 2) ? 1 : 0;
      m_ph = phn;
      if (rise != 0) begin
        if (m_seen != 0) begin
          code = cls(m_cnt + 1);
          if (code == 0) begin m_lock = 0; m_cand = 0; end
          else if (code == m_cand) m_lock = 1;
          else begin m_cand = code; m_lock = 0; end
        end
        m_seen = 1;
        m_cnt = 0;
      end else if (m_cnt == 512) begin
        m_lock = 0; m_cand = 0;
      end else begin
        m_cnt++;
      end
      m_pw = wclk_in ? 1 : 0;
    end
  end

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      chk(bclk == m_bclk[0], "R6 R7 R8 R9 bclk vs model", int'(bclk), m_bclk);
      chk(locked == m_lock[0], "R3 R4 R5 locked vs model", int'(locked), m_lock);
      chk(int'(ratio_code) == m_cand, "R2 R3 ratio_code vs model", int'(ratio_code), m_cand);
    end
  end

  task automatic run_frame(input int p, output int rises);
    rises = 0;
    for (int c = 0; c < p; c++) begin
      @(negedge clk);
      if (bclk && !pb) rises++;
      pb = bclk;
      wclk_in = (c < p / 2);
    end
  endtask

  task automatic group(input int p, input bit lj, input bit ext, input int exp_rises,
                       input int exp_code);
    int r;
    @(negedge clk);
    fmt_lj = lj;
    ext_mode = ext;
    for (int f = 0; f < 4; f++) run_frame(p, r);
    chk(locked == 1'b1, "R4 locked after repeated ratio", int'(locked), 1);
    chk(int'(ratio_code) == exp_code, "R2 ratio code", int'(ratio_code), exp_code);
    chk(r == exp_rises, ext ? "R9 rises per frame" : "R7 rises per frame", r, exp_rises);
  endtask

  initial begin
    int r;
    repeat (3) @(negedge clk);
    chk(bclk == 0 && locked == 0 && ratio_code == 0, "R1 outputs in reset",
        int'({bclk, locked, ratio_code}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(bclk == 0 && locked == 0 && ratio_code == 0, "R1 outputs after reset",
        int'({bclk, locked, ratio_code}), 0);

    // R4: two frames give one measurement, no lock yet
    run_frame(256, r);
    run_frame(256, r);
    chk(locked == 0, "R4 not locked after one measurement", int'(locked), 0);
    chk(ratio_code == 2'd1, "R2 first code", int'(ratio_code), 1);

    group(256, 1'b0, 1'b0, 32, 1);
    group(256, 1'b1, 1'b0, 64, 1);
    group(384, 1'b0, 1'b0, 48, 2);
    group(384, 1'b1, 1'b0, 48, 2);
    group(512, 1'b0, 1'b0, 32, 3);
    group(512, 1'b1, 1'b0, 64, 3);

    // R5: switch ratio while locked at 512
    run_frame(256, r);
    run_frame(256, r);
    chk(locked == 0, "R5 mismatch drops lock", int'(locked), 0);
    chk(ratio_code == 2'd1, "R5 new code taken", int'(ratio_code), 1);
    run_frame(256, r);
    chk(locked == 1, "R5 relock on repeat", int'(locked), 1);

    // R3 and R6: unsupported period
    run_frame(300, r);
    run_frame(300, r);
    run_frame(300, r);
    chk(locked == 0 && ratio_code == 0, "R3 bad period clears", int'({locked, ratio_code}), 0);
    chk(r == 0, "R6 no bclk while unlocked", r, 0);

    // R3: stalled word clock
    group(256, 1'b0, 1'b0, 32, 1);
    for (int c = 0; c < 600; c++) begin
      @(negedge clk);
      wclk_in = 1'b0;
    end
    chk(locked == 0 && ratio_code == 0, "R3 stall clears", int'({locked, ratio_code}), 0);

    // R9: external mode keeps detection, silences output
    group(256, 1'b0, 1'b1, 0, 1);
    group(256, 1'b0, 1'b0, 32, 1);

    // R8: phase restart, check bclk low then high after half divider (I2S 256 -> 8)
    @(negedge clk);
    wclk_in = 1'b1;
    @(negedge clk);
    chk(bclk == 0, "R8 bclk low after word edge", int'(bclk), 0);
    repeat (3) @(negedge clk);
    chk(bclk == 0, "R8 still low before half period", int'(bclk), 0);
    @(negedge clk);
    chk(bclk == 1, "R8 high at half period", int'(bclk), 1);

    repeat (4) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule